// File: doc/BRIEF.md
# Serial Trace Receiver with Ping-Pong Chunk Buffers

The block takes in a trace of fixed length, made of 8-bit samples, over a three-wire synchronous serial link with clock, frame and data lines. It runs on its own fast clock and passes the three serial lines through a synchroniser. It takes one data bit on each detected rising edge of the serial clock. A byte is sent most significant bit first, and the frame line is high only while that first bit is on the wire. Bytes are only assembled once a framed first bit has been seen.

Captured bytes are written into two equal chunk buffers that are used in turn. When a chunk fills, or the last byte of the trace arrives, the block pulses a chunk-ready strobe. The strobe carries the buffer index, the chunk's byte offset within the trace and its length. The final chunk is shorter when the trace length is not a multiple of the chunk size. Writing then moves straight on to the other buffer.

The consumer reads a buffer through a registered read port and hands it back with a release strobe. One cycle after the last chunk is reported, a completion pulse gives the total trace length. A synchronous start input re-arms capture and discards any byte already in flight. If the block must write into a buffer that has not been released, it sets a sticky overflow flag and drops those bytes.

Top module: `trace_chunk_rx`

## Requirements
- R1: Each byte is 8 data bits taken on 8 consecutive serial clock rising edges, most significant bit first; the first of them must have the frame line high.
- R2: A framed bit arriving in the middle of a byte drops the partial byte and starts a new byte at that bit. Bits that arrive without a preceding framed bit are ignored.
- R3: Bytes that complete while capture is not armed are ignored. A byte whose framed bit arrived before start is discarded, so the first byte stored after start is the first byte framed after it.
- R4: Trace byte k is stored in buffer (k / CHUNK_LEN) mod 2 at index k mod CHUNK_LEN. The read port returns buffer rd_sel_i, entry rd_addr_i, one clock after the address is applied.
- R5: When a chunk completes, chunk_vld_o is high for exactly one cycle. With it, chunk_sel_o gives the buffer index, chunk_off_o the offset of the chunk's first byte, and chunk_len_o either CHUNK_LEN or the remaining byte count for the final chunk.
- R6: One cycle after the final chunk strobe, done_o pulses for one cycle and done_len_o holds TRACE_LEN. Capture is then disarmed, and later bytes produce no chunk strobe.
- R7: A byte that would be written into a buffer that has been reported but not released is dropped and is not counted. It sets overflow_o, which stays set until the next start or reset.
- R8: rel_i with rel_sel_i frees that buffer. start_i clears the byte count, clears overflow and all buffer-busy state, selects buffer 0 and arms capture.
- R9: After reset, chunk_vld_o, done_o and overflow_o are low and capture is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receiver clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_frame_i | input | 1 | Frame line, high during the first bit of a byte |
| ser_data_i | input | 1 | Serial data, MSB first |
| start_i | input | 1 | Clears the byte count, selects buffer 0 and arms capture |
| rd_sel_i | input | 1 | Buffer index for the read port |
| rd_addr_i | input | $clog2(CHUNK_LEN) | Entry index for the read port |
| rd_data_o | output | 8 | Read data, one clock after the address |
| rel_i | input | 1 | Release strobe for a buffer |
| rel_sel_i | input | 1 | Buffer index being released |
| chunk_vld_o | output | 1 | One-cycle chunk-ready strobe |
| chunk_sel_o | output | 1 | Buffer holding the reported chunk |
| chunk_off_o | output | $clog2(TRACE_LEN+1) | Trace byte offset of the chunk |
| chunk_len_o | output | $clog2(CHUNK_LEN+1) | Byte count of the chunk |
| done_o | output | 1 | One-cycle completion strobe |
| done_len_o | output | $clog2(TRACE_LEN+1) | Total trace length reported at completion |
| overflow_o | output | 1 | Sticky overflow flag |

## Verification
The hardest situation to reach is a byte landing on a buffer that is still held. The stimulus gets there by sending two full chunks and releasing neither, so the next byte finds buffer 0 busy. It then releases buffer 0 after several dropped bytes and checks that the remaining bytes land at the offset that continues from the last stored byte. A further start with buffer 0 still unreleased shows that start clears the busy state. The stale-byte case is reached by pulsing start halfway through a framed byte and finishing that byte afterwards.

// File: rtl/trc_pkg.sv
package trc_pkg;
    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    typedef struct packed {
        logic [BYTE_W-1:0]    shreg;
        logic [BIT_CNT_W-1:0] cnt;
        logic                 aligned;
        logic                 vld;
        logic [BYTE_W-1:0]    data;
    } deser_st_t;
endpackage

// File: rtl/trc_sync.sv
module trc_sync #(
    parameter int N = 3
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o,
    output logic         rise_o
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic         prev;
        logic         rise;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = async_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2[0];
        st_d.rise = st_q.s2[0] & ~st_q.prev;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    // Bit 0 carries the serial clock; data and frame are delayed one more
    // stage so they line up with the registered rising-edge strobe.
    logic [N-1:0] aligned_q;
    always_ff @(posedge clk_i) begin
        if (rst_i) aligned_q <= '0;
        else       aligned_q <= st_q.s2;
    end

    assign sync_o = aligned_q;
    assign rise_o = st_q.rise;

    // R1: an edge strobe is a single-cycle event
    p_rise_pulse_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> !rise_o);
endmodule

// File: rtl/trc_deser.sv
module trc_deser
    import trc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rise_i,
    input  logic              frame_i,
    input  logic              data_i,
    input  logic              flush_i,
    output logic              byte_vld_o,
    output logic [BYTE_W-1:0] byte_o
);
    deser_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (flush_i) begin
            st_d.aligned = 1'b0;
            st_d.cnt     = '0;
        end else if (rise_i) begin
            if (frame_i) begin
                st_d.shreg   = {{(BYTE_W-1){1'b0}}, data_i};
                st_d.cnt     = BIT_CNT_W'(1);
                st_d.aligned = 1'b1;
            end else if (st_q.aligned) begin
                st_d.shreg = {st_q.shreg[BYTE_W-2:0], data_i};
                if (st_q.cnt == BIT_CNT_W'(BYTE_W-1)) begin
                    st_d.vld     = 1'b1;
                    st_d.data    = {st_q.shreg[BYTE_W-2:0], data_i};
                    st_d.aligned = 1'b0;
                    st_d.cnt     = '0;
                end else begin
                    st_d.cnt = st_q.cnt + BIT_CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign byte_vld_o = st_q.vld;
    assign byte_o     = st_q.data;

    // R1: a byte needs a full run of bit edges, so strobes never touch
    p_byte_spacing_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        byte_vld_o |=> !byte_vld_o);
    // R2: an unaligned receiver cannot emit a byte on the next cycle
    p_no_byte_unaligned_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!st_q.aligned && !rise_i) |=> !byte_vld_o);
endmodule

// File: rtl/trc_chunker.sv
module trc_chunker
    import trc_pkg::*;
#(
    parameter int TRACE_LEN = 3072,
    parameter int CHUNK_LEN = 512,
    localparam int OFF_W = $clog2(TRACE_LEN + 1),
    localparam int LEN_W = $clog2(CHUNK_LEN + 1),
    localparam int IDX_W = $clog2(CHUNK_LEN)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              rel_i,
    input  logic              rel_sel_i,
    output logic              wr_en_o,
    output logic              wr_sel_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              chunk_vld_o,
    output logic              chunk_sel_o,
    output logic [OFF_W-1:0]  chunk_off_o,
    output logic [LEN_W-1:0]  chunk_len_o,
    output logic              done_o,
    output logic [OFF_W-1:0]  done_len_o,
    output logic              overflow_o
);
    typedef struct packed {
        logic             armed;
        logic [OFF_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic             sel;
        logic [1:0]       busy;
        logic             ovf;
        logic             cv;
        logic             csel;
        logic [OFF_W-1:0] coff;
        logic [LEN_W-1:0] clen;
        logic             fin;
        logic             done;
        logic [OFF_W-1:0] dlen;
    } st_t;

    st_t  st_d, st_q;
    logic last_byte, chunk_end;

    always_comb begin
        st_d      = st_q;
        st_d.cv   = 1'b0;
        st_d.fin  = 1'b0;
        st_d.done = 1'b0;
        wr_en_o   = 1'b0;
        wr_sel_o  = st_q.sel;
        wr_idx_o  = st_q.idx;
        wr_data_o = byte_i;
        last_byte = (st_q.cnt == OFF_W'(TRACE_LEN - 1));
        chunk_end = (st_q.idx == IDX_W'(CHUNK_LEN - 1)) || last_byte;

        if (st_q.cv && st_q.fin) begin
            st_d.done = 1'b1;
            st_d.dlen = OFF_W'(TRACE_LEN);
        end
        if (rel_i) st_d.busy[rel_sel_i] = 1'b0;

        if (start_i) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
            st_d.idx   = '0;
            st_d.sel   = 1'b0;
            st_d.busy  = '0;
            st_d.ovf   = 1'b0;
        end else if (st_q.armed && byte_vld_i) begin
            if (st_d.busy[st_q.sel]) begin
                st_d.ovf = 1'b1;
            end else begin
                wr_en_o  = 1'b1;
                st_d.cnt = st_q.cnt + OFF_W'(1);
                st_d.idx = st_q.idx + IDX_W'(1);
                if (chunk_end) begin
                    st_d.busy[st_q.sel] = 1'b1;
                    st_d.cv   = 1'b1;
                    st_d.csel = st_q.sel;
                    st_d.coff = st_q.cnt - OFF_W'(st_q.idx);
                    st_d.clen = LEN_W'(st_q.idx) + LEN_W'(1);
                    st_d.sel  = ~st_q.sel;
                    st_d.idx  = '0;
                    if (last_byte) begin
                        st_d.armed = 1'b0;
                        st_d.fin   = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign chunk_vld_o = st_q.cv;
    assign chunk_sel_o = st_q.csel;
    assign chunk_off_o = st_q.coff;
    assign chunk_len_o = st_q.clen;
    assign done_o      = st_q.done;
    assign done_len_o  = st_q.dlen;
    assign overflow_o  = st_q.ovf;

    p_len_range_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        chunk_vld_o |-> (chunk_len_o != '0 && chunk_len_o <= LEN_W'(CHUNK_LEN)));
    p_done_follows_chunk_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> $past(chunk_vld_o));
    p_idle_no_chunk_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!st_q.armed && !start_i) |=> !chunk_vld_o);
    p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (overflow_o && !start_i) |=> overflow_o);
    p_start_clears_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> (st_q.armed && st_q.cnt == '0 && !st_q.sel && st_q.busy == '0 && !overflow_o));
endmodule

// File: rtl/trc_pp_mem.sv
module trc_pp_mem
    import trc_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              rd_sel_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [BYTE_W-1:0] rd_data_o
);
    logic [BYTE_W-1:0] mem [2][DEPTH];
    logic [BYTE_W-1:0] rd_d, rd_q;

    always_ff @(posedge clk_i) begin
        if (wr_en_i) mem[wr_sel_i][wr_idx_i] <= wr_data_i;
    end

    always_comb rd_d = mem[rd_sel_i][rd_idx_i];

    always_ff @(posedge clk_i) begin
        if (rst_i) rd_q <= '0;
        else       rd_q <= rd_d;
    end

    assign rd_data_o = rd_q;
endmodule

// File: rtl/trace_chunk_rx.sv
module trace_chunk_rx
    import trc_pkg::*;
#(
    parameter int TRACE_LEN = 3072,
    parameter int CHUNK_LEN = 512
) (
    input  logic                           clk_i,
    input  logic                           rst_i,
    input  logic                           ser_clk_i,
    input  logic                           ser_frame_i,
    input  logic                           ser_data_i,
    input  logic                           start_i,
    input  logic                           rd_sel_i,
    input  logic [$clog2(CHUNK_LEN)-1:0]   rd_addr_i,
    output logic [7:0]                     rd_data_o,
    input  logic                           rel_i,
    input  logic                           rel_sel_i,
    output logic                           chunk_vld_o,
    output logic                           chunk_sel_o,
    output logic [$clog2(TRACE_LEN+1)-1:0] chunk_off_o,
    output logic [$clog2(CHUNK_LEN+1)-1:0] chunk_len_o,
    output logic                           done_o,
    output logic [$clog2(TRACE_LEN+1)-1:0] done_len_o,
    output logic                           overflow_o
);
    localparam int IDX_W = $clog2(CHUNK_LEN);

    logic [2:0]        ser_sync;
    logic              ser_rise;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_data;
    logic              wr_en, wr_sel;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;

    trc_sync #(.N(3)) i_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i ({ser_data_i, ser_frame_i, ser_clk_i}),
        .sync_o  (ser_sync),
        .rise_o  (ser_rise)
    );

    trc_deser i_deser (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .rise_i     (ser_rise),
        .frame_i    (ser_sync[1]),
        .data_i     (ser_sync[2]),
        .flush_i    (start_i),
        .byte_vld_o (byte_vld),
        .byte_o     (byte_data)
    );

    trc_chunker #(.TRACE_LEN(TRACE_LEN), .CHUNK_LEN(CHUNK_LEN)) i_chunker (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .start_i     (start_i),
        .byte_vld_i  (byte_vld),
        .byte_i      (byte_data),
        .rel_i       (rel_i),
        .rel_sel_i   (rel_sel_i),
        .wr_en_o     (wr_en),
        .wr_sel_o    (wr_sel),
        .wr_idx_o    (wr_idx),
        .wr_data_o   (wr_data),
        .chunk_vld_o (chunk_vld_o),
        .chunk_sel_o (chunk_sel_o),
        .chunk_off_o (chunk_off_o),
        .chunk_len_o (chunk_len_o),
        .done_o      (done_o),
        .done_len_o  (done_len_o),
        .overflow_o  (overflow_o)
    );

    trc_pp_mem #(.DEPTH(CHUNK_LEN)) i_mem (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .rd_sel_i  (rd_sel_i),
        .rd_idx_i  (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

    // R5: the ready strobe never lasts two cycles
    p_chunk_pulse_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        chunk_vld_o |=> !chunk_vld_o);
    // R6: completion is a one-cycle strobe
    p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);
endmodule

// File: tb/test_trace_chunk_rx.sv
`timescale 1ns/1ps
module test_trace_chunk_rx;
    localparam int TL = 40;
    localparam int CL = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, sfrm = 1'b0, sdat = 1'b0;
    logic start = 1'b0, rel = 1'b0, rel_sel = 1'b0, rd_sel = 1'b0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic chunk_vld, chunk_sel, done, ovf;
    logic [5:0] chunk_off, done_len;
    logic [4:0] chunk_len;

    always #2.5 clk = ~clk;

    trace_chunk_rx #(.TRACE_LEN(TL), .CHUNK_LEN(CL)) i_trace_chunk_rx (
        .clk_i(clk), .rst_i(rst), .ser_clk_i(sclk), .ser_frame_i(sfrm),
        .ser_data_i(sdat), .start_i(start), .rd_sel_i(rd_sel),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rel_i(rel),
        .rel_sel_i(rel_sel), .chunk_vld_o(chunk_vld), .chunk_sel_o(chunk_sel),
        .chunk_off_o(chunk_off), .chunk_len_o(chunk_len), .done_o(done),
        .done_len_o(done_len), .overflow_o(ovf)
    );

    int n_chk = 0, n_err = 0;
    int cyc = 0, n_ev = 0, n_done = 0;
    int ev_sel[64], ev_off[64], ev_len[64], ev_cyc[64];
    int dn_cyc, dn_len;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (chunk_vld && n_ev < 64) begin
            ev_sel[n_ev] = chunk_sel; ev_off[n_ev] = chunk_off;
            ev_len[n_ev] = chunk_len; ev_cyc[n_ev] = cyc;
            n_ev = n_ev + 1;
        end
        if (done) begin
            dn_cyc = cyc; dn_len = done_len; n_done = n_done + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb, input logic framed);
        for (int i = 0; i < nb; i++) begin
            sdat = b[7-i];
            sfrm = framed && (i == 0);
            tick(4);
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
        end
        sfrm = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8, 1'b1);
    endtask

    task automatic pulse_start();
        start = 1'b1; tick(1); start = 1'b0;
    endtask

    task automatic release_buf(input logic s);
        rel_sel = s; rel = 1'b1; tick(1); rel = 1'b0;
    endtask

    task automatic read_mem(input logic s, input int a, output int v);
        rd_sel = s; rd_addr = 4'(a);
        @(posedge clk); @(negedge clk);
        v = rd_data;
        #1;
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'((k * 37 + seed * 11) ^ 8'h5A);
    endfunction

    task automatic t_reset();
        chk("R9 chunk_vld", chunk_vld, 0);
        chk("R9 done", done, 0);
        chk("R9 overflow", ovf, 0);
    endtask

    task automatic t_unarmed();
        int b = n_ev;
        send_byte(8'hAA); send_byte(8'h55); tick(8);
        chk("R3 no chunk while unarmed", n_ev - b, 0);
    endtask

    task automatic t_align();
        int v; int b = n_ev;
        send_bits(8'hA5, 4, 1'b1);
        pulse_start();
        send_bits(8'h50, 4, 1'b0);
        send_byte(8'h3C); tick(8);
        read_mem(1'b0, 0, v);
        chk("R3 stale byte dropped, first byte after start", v, 8'h3C);
        send_bits(8'hFF, 8, 1'b0);
        send_byte(8'h5A); tick(8);
        read_mem(1'b0, 1, v);
        chk("R2 unframed bits ignored", v, 8'h5A);
        send_bits(8'hC3, 5, 1'b1);
        send_byte(8'h81); tick(8);
        read_mem(1'b0, 2, v);
        chk("R2 mid-byte frame resync", v, 8'h81);
        chk("R2 no chunk yet", n_ev - b, 0);
    endtask

    task automatic t_full_trace(input int seed);
        int b, ci, v, exp_ev, last_ev;
        pulse_start();
        b = n_ev; ci = 0;
        for (int k = 0; k < TL; k++) begin
            send_byte(pat(seed, k)); tick(8);
            exp_ev = ((k + 1) / CL) + (((k + 1) == TL && (TL % CL) != 0) ? 1 : 0);
            chk("R5 chunk strobe count", n_ev - b, exp_ev);
            if (n_ev - b > ci) begin
                int e = b + ci;
                int elen = (TL - CL * ci < CL) ? TL - CL * ci : CL;
                chk("R5 chunk buffer", ev_sel[e], ci % 2);
                chk("R5 chunk offset", ev_off[e], CL * ci);
                chk("R5 chunk length", ev_len[e], elen);
                for (int j = 0; j < elen; j++) begin
                    read_mem(1'(ci % 2), j, v);
                    chk("R4 R1 stored byte", v, pat(seed, CL * ci + j));
                end
                release_buf(1'(ci % 2));
                ci++;
            end
        end
        last_ev = b + ci - 1;
        chk("R6 done count", n_done, 1 + (seed - 1));
        chk("R6 done length", dn_len, TL);
        chk("R6 done one cycle after final chunk", dn_cyc, ev_cyc[last_ev] + 1);
        send_byte(8'h11); tick(8);
        chk("R6 no chunk after completion", n_ev - b, ci);
        chk("R7 no overflow when released", ovf, 0);
    endtask

    task automatic t_overflow();
        int b, v;
        pulse_start();
        b = n_ev;
        for (int k = 0; k < 2 * CL; k++) send_byte(pat(7, k));
        tick(8);
        chk("R7 two chunks before overflow", n_ev - b, 2);
        chk("R7 no overflow yet", ovf, 0);
        send_byte(8'hEE); tick(8);
        chk("R7 overflow set on busy buffer", ovf, 1);
        for (int k = 0; k < 7; k++) send_byte(8'hEE);
        tick(8);
        chk("R7 dropped bytes make no chunk", n_ev - b, 2);
        release_buf(1'b0);
        for (int k = 0; k < TL - 2 * CL; k++) send_byte(pat(9, k));
        tick(8);
        chk("R7 chunk after release", n_ev - b, 3);
        chk("R7 offset continues after drop", ev_off[b + 2], 2 * CL);
        chk("R5 short final length", ev_len[b + 2], TL - 2 * CL);
        chk("R8 released buffer reused", ev_sel[b + 2], 0);
        read_mem(1'b0, 0, v);
        chk("R7 first kept byte", v, pat(9, 0));
        read_mem(1'b0, TL - 2 * CL - 1, v);
        chk("R7 last kept byte", v, pat(9, TL - 2 * CL - 1));
        chk("R7 overflow sticky", ovf, 1);
        pulse_start(); tick(1);
        chk("R8 start clears overflow", ovf, 0);
        b = n_ev;
        for (int k = 0; k < CL; k++) send_byte(pat(3, k));
        tick(8);
        chk("R8 start frees busy buffer", n_ev - b, 1);
        chk("R8 start selects buffer 0", ev_sel[b], 0);
        chk("R8 offset restarts", ev_off[b], 0);
        chk("R8 no overflow after start", ovf, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(2);
        t_reset();
        t_unarmed();
        t_align();
        t_full_trace(1);
        t_full_trace(2);
        t_overflow();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule